// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes 23-bit configuration words over a three-wire serial link (a bit clock, a data line and a load strobe) and places each word in one of four holding registers. The four registers hold the reference-divider settings and the feedback-divider settings of two synthesizer channels, a low-band channel and a high-band channel. The serial pins are asynchronous to the block. They pass through synchronizers into the system clock domain, and the block finds their rising edges there.

Data is shifted in one bit per serial-clock rise, most significant bit first. The last two bits shifted in are the routing code. When the load strobe rises, the held word is checked. If it is valid, all of its fields move into the chosen register in a single system-clock cycle. A word that programs a division ratio below 3 is dropped, and a sticky error flag is raised.

A small state machine controls the load:
- **ST_SHIFT** accepts serial bits.
- On a strobe rise it captures the word and goes to **ST_CHECK**.
- ST_CHECK moves to **ST_COMMIT** (ratio legal) or to **ST_REJECT** (ratio illegal).
- Both of those states go to **ST_DRAIN**.
- ST_DRAIN waits for the strobe to fall, then returns to ST_SHIFT.

Top module: `serial_word_loader`

## Requirements
- R1: Each synchronized rising edge of `ser_clk` while `ser_le` is low shifts `ser_data` into a 23-bit register, most significant bit first. Only the last 23 bits shifted before a load count; earlier bits are dropped.
- R2: A load writes exactly one of the four registers. The routing is taken from word bit 0 (first code bit) and bit 1 (second code bit), where bit 0 is the last bit shifted in:
  - 0,0 selects the low-band reference register.
  - 1,0 selects the high-band reference register.
  - 0,1 selects the low-band divider register.
  - 1,1 selects the high-band divider register.
- R3: Reference word fields:
  - bits 2 and 3 drive `*_mon_sel[0]` and `*_mon_sel[1]`.
  - bits 17:4 drive `*_ref_ratio`, with bit 4 as LSB.
  - bit 18 drives `*_cp_hi`.
  - bits 22:19 are ignored.
- R4: Divider word fields:
  - bit 2 drives `*_lock_src`.
  - bit 3 drives `*_mod_sel`.
  - bit 4 drives `*_pd_pol`.
  - bits 11:5 drive `*_swallow`, with bit 5 as LSB.
  - bits 22:12 drive `*_fb_ratio`, with bit 12 as LSB.
- R5: `*_cp_hi` is 1 (high pump current) when bit 18 of a reference word is 1, and 0 (low current) when it is 0.
- R6: A reference word with ratio below 3, or a divider word with feedback ratio below 3, changes no register and sets `cfg_err`. `cfg_err` stays set until reset.
- R7: Serial-clock edges that arrive while `ser_le` is high do not alter the shift register.
- R8: After reset the outputs hold these values:
  - reference ratio 3, `mon_sel` 0, `cp_hi` 0.
  - feedback ratio 3, swallow 0, `mod_sel` 0, `pd_pol` 1, `lock_src` 0.
  - `cfg_err` 0.
- R9: With `ser_le` held high for at least 6 system clocks, every field of the written register changes together at the fifth system-clock rising edge after `ser_le` is first sampled high. The old values remain visible until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe |
| lo_ref_ratio | output | 14 | Low-band reference ratio |
| lo_mon_sel | output | 2 | Low-band monitor select |
| lo_cp_hi | output | 1 | Low-band high pump current |
| hi_ref_ratio | output | 14 | High-band reference ratio |
| hi_mon_sel | output | 2 | High-band monitor select |
| hi_cp_hi | output | 1 | High-band high pump current |
| lo_fb_ratio | output | 11 | Low-band feedback ratio |
| lo_swallow | output | 7 | Low-band swallow count |
| lo_mod_sel | output | 1 | Low-band prescaler modulus select |
| lo_pd_pol | output | 1 | Low-band phase-detector polarity |
| lo_lock_src | output | 1 | Low-band lock/monitor pin source |
| hi_fb_ratio | output | 11 | High-band feedback ratio |
| hi_swallow | output | 7 | High-band swallow count |
| hi_mod_sel | output | 1 | High-band prescaler modulus select |
| hi_pd_pol | output | 1 | High-band phase-detector polarity |
| hi_lock_src | output | 1 | High-band lock/monitor pin source |
| cfg_err | output | 1 | Sticky illegal-ratio flag |

## Verification
A load result is counted in system-clock edges from the first edge that samples `ser_le` high:
- edges 1 and 2 pass the strobe through the synchronizer;
- edge 3 captures the word;
- edge 4 checks it;
- edge 5 writes the chosen register, or `cfg_err` for a rejected word.

The bench raises the strobe just after a falling clock edge and samples on falling edges. It expects every output unchanged after the fourth rising edge and the new values after the fifth. Serial bits are spaced several system clocks apart, so the synchronized data is stable before each synchronized clock rise.

// File: rtl/loader_pkg.sv
package loader_pkg;

    localparam int WORD_W      = 23;
    localparam int R_W         = 14;
    localparam int N_W         = 11;
    localparam int A_W         = 7;
    localparam int NUM_CH      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int MIN_RATIO   = 3;

    // routing code and field positions (bit 0 is last shifted in)
    localparam int CODE0_POS = 0;
    localparam int CODE1_POS = 1;
    localparam int MON_LSB   = 2;
    localparam int R_LSB     = 4;
    localparam int CP_POS    = R_LSB + R_W;
    localparam int LOCK_POS  = 2;
    localparam int MOD_POS   = 3;
    localparam int POL_POS   = 4;
    localparam int A_LSB     = 5;
    localparam int N_LSB     = A_LSB + A_W;

    typedef enum logic [2:0] {
        ST_SHIFT  = 3'd0,
        ST_CHECK  = 3'd1,
        ST_COMMIT = 3'd2,
        ST_REJECT = 3'd3,
        ST_DRAIN  = 3'd4
    } st_e;

    typedef struct packed {
        logic [1:0]     mon;
        logic [R_W-1:0] ratio;
        logic           cp_hi;
    } ref_cfg_t;

    typedef struct packed {
        logic           lock_src;
        logic           mod_sel;
        logic           pol;
        logic [A_W-1:0] swal;
        logic [N_W-1:0] ratio;
    } div_cfg_t;

    localparam ref_cfg_t REF_DEFAULT = '{mon: 2'b00, ratio: R_W'(MIN_RATIO), cp_hi: 1'b0};
    localparam div_cfg_t DIV_DEFAULT = '{lock_src: 1'b0, mod_sel: 1'b0, pol: 1'b1,
                                         swal: '0, ratio: N_W'(MIN_RATIO)};

    function automatic ref_cfg_t unpack_ref(input logic [WORD_W-1:0] w);
        ref_cfg_t c;
        c.mon   = w[MON_LSB +: 2];
        c.ratio = w[R_LSB +: R_W];
        c.cp_hi = w[CP_POS];
        return c;
    endfunction

    function automatic div_cfg_t unpack_div(input logic [WORD_W-1:0] w);
        div_cfg_t c;
        c.lock_src = w[LOCK_POS];
        c.mod_sel  = w[MOD_POS];
        c.pol      = w[POL_POS];
        c.swal     = w[A_LSB +: A_W];
        c.ratio    = w[N_LSB +: N_W];
        return c;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe[0] <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader import loader_pkg::*; (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_le,
    output logic [R_W-1:0] lo_ref_ratio,
    output logic [1:0]     lo_mon_sel,
    output logic           lo_cp_hi,
    output logic [R_W-1:0] hi_ref_ratio,
    output logic [1:0]     hi_mon_sel,
    output logic           hi_cp_hi,
    output logic [N_W-1:0] lo_fb_ratio,
    output logic [A_W-1:0] lo_swallow,
    output logic           lo_mod_sel,
    output logic           lo_pd_pol,
    output logic           lo_lock_src,
    output logic [N_W-1:0] hi_fb_ratio,
    output logic [A_W-1:0] hi_swallow,
    output logic           hi_mod_sel,
    output logic           hi_pd_pol,
    output logic           hi_lock_src,
    output logic           cfg_err
);
    // ---------------- input synchronizers and edge detect ----------------
    logic [2:0] pins_sync;
    logic       sclk_q, din_q, le_q;
    logic       sclk_d, le_d;
    logic       sclk_rise, le_rise;

    edge_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_le, ser_data, ser_clk}),
        .q     (pins_sync)
    );

    assign {le_q, din_q, sclk_q} = pins_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_q;
            le_d   <= le_q;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_d;
    assign le_rise   = le_q & ~le_d;

    // ---------------- shift register ----------------
    st_e               st, st_nxt;
    logic [WORD_W-1:0] shift_word;
    logic [WORD_W-1:0] held;
    logic              bad;

    word_shifter #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (st == ST_SHIFT && sclk_rise && !le_q),
        .din      (din_q),
        .word     (shift_word)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_SHIFT;
        else        st <= st_nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_SHIFT:  if (le_rise) st_nxt = ST_CHECK;
            ST_CHECK:  st_nxt = bad ? ST_REJECT : ST_COMMIT;
            ST_COMMIT: st_nxt = ST_DRAIN;
            ST_REJECT: st_nxt = ST_DRAIN;
            ST_DRAIN:  if (!le_q) st_nxt = ST_SHIFT;
            default:   st_nxt = ST_SHIFT;
        endcase
    end

    // ---------------- word capture and ratio check ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        held <= '0;
        else if (st == ST_SHIFT && le_rise) held <= shift_word;
    end

    always_comb begin
        if (held[CODE1_POS]) bad = held[N_LSB +: N_W] < N_W'(MIN_RATIO);
        else                 bad = held[R_LSB +: R_W] < R_W'(MIN_RATIO);
    end

    // ---------------- outputs: error flag and holding registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cfg_err <= 1'b0;
        else if (st == ST_REJECT) cfg_err <= 1'b1;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        ref_cfg_t ref_q;
        div_cfg_t div_q;
        logic     hit;

        assign hit = (st == ST_COMMIT) && (held[CODE0_POS] == 1'(ch));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ref_q <= REF_DEFAULT;
                div_q <= DIV_DEFAULT;
            end else if (hit) begin
                if (held[CODE1_POS]) div_q <= unpack_div(held);
                else                 ref_q <= unpack_ref(held);
            end
        end
    end

    assign lo_ref_ratio = g_ch[0].ref_q.ratio;
    assign lo_mon_sel   = g_ch[0].ref_q.mon;
    assign lo_cp_hi     = g_ch[0].ref_q.cp_hi;
    assign hi_ref_ratio = g_ch[1].ref_q.ratio;
    assign hi_mon_sel   = g_ch[1].ref_q.mon;
    assign hi_cp_hi     = g_ch[1].ref_q.cp_hi;
    assign lo_fb_ratio  = g_ch[0].div_q.ratio;
    assign lo_swallow   = g_ch[0].div_q.swal;
    assign lo_mod_sel   = g_ch[0].div_q.mod_sel;
    assign lo_pd_pol    = g_ch[0].div_q.pol;
    assign lo_lock_src  = g_ch[0].div_q.lock_src;
    assign hi_fb_ratio  = g_ch[1].div_q.ratio;
    assign hi_swallow   = g_ch[1].div_q.swal;
    assign hi_mod_sel   = g_ch[1].div_q.mod_sel;
    assign hi_pd_pol    = g_ch[1].div_q.pol;
    assign hi_lock_src  = g_ch[1].div_q.lock_src;
endmodule

// File: rtl/loader_checker.sv
module loader_checker import loader_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_le,
    input logic [WORD_W-1:0] shift_word,
    input logic [R_W-1:0]    lo_ref_ratio,
    input logic [1:0]        lo_mon_sel,
    input logic              lo_cp_hi,
    input logic [R_W-1:0]    hi_ref_ratio,
    input logic [1:0]        hi_mon_sel,
    input logic              hi_cp_hi,
    input logic [N_W-1:0]    lo_fb_ratio,
    input logic [A_W-1:0]    lo_swallow,
    input logic              lo_mod_sel,
    input logic              lo_pd_pol,
    input logic              lo_lock_src,
    input logic [N_W-1:0]    hi_fb_ratio,
    input logic [A_W-1:0]    hi_swallow,
    input logic              hi_mod_sel,
    input logic              hi_pd_pol,
    input logic              hi_lock_src,
    input logic              cfg_err
);
    localparam int RW = R_W + 3;
    localparam int DW = N_W + A_W + 3;

    logic [RW-1:0] lo_ref_v, hi_ref_v, lo_ref_p, hi_ref_p;
    logic [DW-1:0] lo_div_v, hi_div_v, lo_div_p, hi_div_p;
    logic          seen;
    logic [3:0]    chg;

    assign lo_ref_v = {lo_ref_ratio, lo_mon_sel, lo_cp_hi};
    assign hi_ref_v = {hi_ref_ratio, hi_mon_sel, hi_cp_hi};
    assign lo_div_v = {lo_fb_ratio, lo_swallow, lo_mod_sel, lo_pd_pol, lo_lock_src};
    assign hi_div_v = {hi_fb_ratio, hi_swallow, hi_mod_sel, hi_pd_pol, hi_lock_src};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            lo_ref_p <= '0;
            hi_ref_p <= '0;
            lo_div_p <= '0;
            hi_div_p <= '0;
        end else begin
            seen     <= 1'b1;
            lo_ref_p <= lo_ref_v;
            hi_ref_p <= hi_ref_v;
            lo_div_p <= lo_div_v;
            hi_div_p <= hi_div_v;
        end
    end

    assign chg = {lo_ref_v != lo_ref_p, hi_ref_v != hi_ref_p,
                  lo_div_v != lo_div_p, hi_div_v != hi_div_p};

    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> $onehot0(chg));

    assert_change_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (|chg)) |-> $past(ser_le, 5));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_reject_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $rose(cfg_err)) |-> (chg == 4'b0000 && $past(ser_le, 5)));

    assert_no_shift_le_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ser_le, 4) && $past(ser_le, 3)) |-> $stable(shift_word));
endmodule

bind serial_word_loader loader_checker u_chk (.*);

// File: tb/tb_serial_word_loader.sv
module tb_serial_word_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;

    logic [13:0] lo_ref_ratio, hi_ref_ratio;
    logic [1:0]  lo_mon_sel, hi_mon_sel;
    logic        lo_cp_hi, hi_cp_hi;
    logic [10:0] lo_fb_ratio, hi_fb_ratio;
    logic [6:0]  lo_swallow, hi_swallow;
    logic        lo_mod_sel, lo_pd_pol, lo_lock_src;
    logic        hi_mod_sel, hi_pd_pol, hi_lock_src;
    logic        cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // bench model
    logic [22:0] m_sr = '0;
    int e_r[2], e_mon[2], e_cp[2], e_n[2], e_a[2], e_sw[2], e_pol[2], e_lk[2];
    int e_err;

    always #4 clk = ~clk;

    serial_word_loader dut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "lo_ref_ratio", int'(lo_ref_ratio), e_r[0]);
        chk(req, "lo_mon_sel",   int'(lo_mon_sel),   e_mon[0]);
        chk(req, "lo_cp_hi",     int'(lo_cp_hi),     e_cp[0]);
        chk(req, "hi_ref_ratio", int'(hi_ref_ratio), e_r[1]);
        chk(req, "hi_mon_sel",   int'(hi_mon_sel),   e_mon[1]);
        chk(req, "hi_cp_hi",     int'(hi_cp_hi),     e_cp[1]);
        chk(req, "lo_fb_ratio",  int'(lo_fb_ratio),  e_n[0]);
        chk(req, "lo_swallow",   int'(lo_swallow),   e_a[0]);
        chk(req, "lo_mod_sel",   int'(lo_mod_sel),   e_sw[0]);
        chk(req, "lo_pd_pol",    int'(lo_pd_pol),    e_pol[0]);
        chk(req, "lo_lock_src",  int'(lo_lock_src),  e_lk[0]);
        chk(req, "hi_fb_ratio",  int'(hi_fb_ratio),  e_n[1]);
        chk(req, "hi_swallow",   int'(hi_swallow),   e_a[1]);
        chk(req, "hi_mod_sel",   int'(hi_mod_sel),   e_sw[1]);
        chk(req, "hi_pd_pol",    int'(hi_pd_pol),    e_pol[1]);
        chk(req, "hi_lock_src",  int'(hi_lock_src),  e_lk[1]);
        chk(req, "cfg_err",      int'(cfg_err),      e_err);
    endtask

    // model of a load from the requirements (R2..R6)
    task automatic model_load();
        int ch;
        int r;
        int n;
        ch = int'(m_sr[0]);
        r  = int'(m_sr[17:4]);
        n  = int'(m_sr[22:12]);
        if (!m_sr[1]) begin
            if (r < 3) e_err = 1;
            else begin
                e_r[ch] = r; e_mon[ch] = int'(m_sr[3:2]); e_cp[ch] = int'(m_sr[18]);
            end
        end else begin
            if (n < 3) e_err = 1;
            else begin
                e_n[ch] = n; e_a[ch] = int'(m_sr[11:5]); e_sw[ch] = int'(m_sr[3]);
                e_pol[ch] = int'(m_sr[4]); e_lk[ch] = int'(m_sr[2]);
            end
        end
    endtask

    function automatic logic [22:0] ref_word(input bit ch, input logic [1:0] mon,
                                             input int r, input bit cs, input logic [3:0] tail);
        logic [22:0] w;
        logic [13:0] rv;
        rv = r[13:0];
        w = '0;
        w[0] = ch; w[1] = 1'b0; w[3:2] = mon; w[17:4] = rv; w[18] = cs; w[22:19] = tail;
        return w;
    endfunction

    function automatic logic [22:0] div_word(input bit ch, input bit lk, input bit sw,
                                             input bit pol, input int a, input int n);
        logic [22:0] w;
        logic [6:0]  av;
        logic [10:0] nv;
        av = a[6:0];
        nv = n[10:0];
        w = '0;
        w[0] = ch; w[1] = 1'b1; w[2] = lk; w[3] = sw; w[4] = pol; w[11:5] = av; w[22:12] = nv;
        return w;
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk) ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
        m_sr = {m_sr[21:0], b};
    endtask

    task automatic send_word(input logic [22:0] w);
        for (int i = 22; i >= 0; i--) send_bit(w[i]);
    endtask

    // strobe with R9 timing check; noise = serial clocks given while strobe high (R7)
    task automatic pulse_le(input string req, input int noise);
        @(negedge clk) ser_le = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R9 before edge 5");
        @(negedge clk);
        model_load();
        check_all(req);
        for (int k = 0; k < noise; k++) begin
            ser_data = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        check_all("R8");
    endtask

    task automatic t_lo_ref();
        send_word(ref_word(1'b0, 2'b01, 1000, 1'b1, 4'b1010));
        pulse_le("R2 R3 R5 lo ref", 0);
    endtask

    task automatic t_hi_ref();
        send_word(ref_word(1'b1, 2'b10, 16383, 1'b0, 4'b0101));
        pulse_le("R2 R3 R5 hi ref", 0);
    endtask

    task automatic t_lo_div();
        send_word(div_word(1'b0, 1'b1, 1'b1, 1'b0, 127, 2047));
        pulse_le("R2 R4 lo div", 0);
    endtask

    task automatic t_hi_div_min();
        send_word(div_word(1'b1, 1'b0, 1'b1, 1'b1, 0, 3));
        pulse_le("R4 hi div min ratio", 0);
    endtask

    task automatic t_leading_bits();
        send_bit(1'b1);
        send_bit(1'b0);
        send_word(ref_word(1'b0, 2'b11, 3, 1'b0, 4'b1111));
        pulse_le("R1 extra leading bits", 0);
    endtask

    task automatic t_le_noise();
        send_word(ref_word(1'b1, 2'b01, 500, 1'b1, 4'b0000));
        pulse_le("R7 load before noise", 6);
        pulse_le("R7 reload unchanged", 0);
    endtask

    task automatic t_reject_ref();
        send_word(ref_word(1'b0, 2'b10, 2, 1'b1, 4'b0000));
        pulse_le("R6 ref ratio 2", 0);
    endtask

    task automatic t_reject_div();
        send_word(div_word(1'b1, 1'b1, 1'b0, 1'b0, 5, 0));
        pulse_le("R6 div ratio 0", 0);
    endtask

    task automatic t_err_sticky();
        send_word(div_word(1'b0, 1'b0, 1'b0, 1'b1, 9, 100));
        pulse_le("R6 sticky after valid load", 0);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            e_r[c] = 3; e_mon[c] = 0; e_cp[c] = 0;
            e_n[c] = 3; e_a[c] = 0; e_sw[c] = 0; e_pol[c] = 1; e_lk[c] = 0;
        end
        e_err = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_lo_ref();
        t_hi_ref();
        t_lo_div();
        t_hi_div_min();
        t_leading_bits();
        t_le_noise();
        t_reject_ref();
        t_reject_div();
        t_err_sticky();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule